// File: doc/BRIEF.md
# Backlight PWM Generator with Locked Duty Update

This block turns a programmed period and a 16-bit duty word into a single backlight PWM output. A small write-only register port holds four registers: the period (a count value plus a bit-count that sets how many of its low bits are used), the control word (output enable, fractional mode, duty word), a lock word and a reference divider that slows the PWM count clock relative to `clk`.

The duty word is left-aligned: its upper bit-count bits are the integer number of high counts per period. In fractional mode the remaining low bits are a fraction of one count. This fraction is built up over successive periods, and a period's high time grows by one count whenever the build-up overflows. The duty word is double-buffered. Every write lands in a shadow copy and moves to the active copy only at a period boundary, so a pulse is never cut short. While the lock bit is set, the shadow fills but no transfer is scheduled. Clearing the lock schedules the transfer, and `pending_o` stays high until the transfer takes place.

Top module: `bklt_pwm`

## Requirements
- R1: After reset `pwm_o` and `pending_o` are low.
- R2: Register select 0 is the period register: bits [15:0] are the period value and bits [19:16] the bit-count B, where B=0 means 16. Only the low B bits of the value are kept, giving P. If P is 0 the period is the all-ones value of B bits. Each PWM period lasts P counts.
- R3: Register select 1 is the control register: bits [15:0] are the duty word, bit 16 enables fractional mode and bit 17 enables the output. With fractional mode off, the integer duty D is the duty word shifted right by 16-B. The output is high for D counts of each period and low for the rest. The low 16-B bits are ignored.
- R4: If D is 0 the output stays low. If D is at or above P the output stays high.
- R5: With fractional mode on, F is the low 16-B bits of the duty word. Over any 2^(16-B) consecutive periods, the output is high for 2^(16-B)*D + F counts when D < P.
- R6: While the enable bit is clear, `pwm_o` is low from the second clock edge after the write that cleared it.
- R7: Register select 3 bits [15:0] hold the divider N. Each PWM count lasts N+1 clocks.
- R8: Register select 2 bit 0 is the lock. While it is set, duty writes do not change the waveform and do not raise `pending_o`.
- R9: A write that clears the lock after a duty write made under the lock raises `pending_o` in the next cycle. `pending_o` clears at the next period boundary, and the new duty is in effect from then on.
- R10: A duty write made while unlocked raises `pending_o` in the next cycle. The duty moves to the active copy only at a period boundary.
- R11: Lock register bit 1 is stored and shown on `master_ign_o`. It has no effect on the waveform or on duty updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 period, 1 control, 2 lock, 3 divider |
| wr_data | input | 20 | Write data |
| pwm_o | output | 1 | Backlight PWM output |
| pending_o | output | 1 | Duty transfer outstanding |
| master_ign_o | output | 1 | Stored lock-ignore bit |

## Verification
A register write takes effect at the clock edge that samples it. `pending_o` therefore changes one cycle after the write, and `pwm_o` follows enable changes one edge after that. A new duty value takes effect only at the next period boundary, at most P*(N+1) clocks later. For these reasons the bench checks the pending flag and the disable exactly in the cycle they are due. It polls for the clearing of pending against a bound of one period plus a margin. It checks the duty only after a settling gap of several periods, by counting high clocks over a window that is a whole number of repeats of the waveform. That count does not depend on the phase at which the window starts.

// File: rtl/bklt_pkg.sv
package bklt_pkg;

    localparam int DUTY_W = 16;
    localparam int BITS_W = 4;
    localparam int BEFF_W = 5;
    localparam int REG_W  = DUTY_W + BITS_W;

    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_LOCK   = 2'd2,
        SEL_DIV    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [DUTY_W-1:0] len;
        logic [BEFF_W-1:0] bits;
    } period_t;

    typedef struct packed {
        logic en;
        logic frac;
    } mode_t;

    function automatic logic [BEFF_W-1:0] eff_bits(input logic [BITS_W-1:0] raw);
        return (raw == '0) ? BEFF_W'(DUTY_W) : {1'b0, raw};
    endfunction

    function automatic logic [DUTY_W-1:0] bit_mask(input logic [BEFF_W-1:0] b);
        logic [DUTY_W:0] t;
        t = ({{DUTY_W{1'b0}}, 1'b1} << b) - 1'b1;
        return t[DUTY_W-1:0];
    endfunction

    function automatic logic [DUTY_W-1:0] int_part(input logic [DUTY_W-1:0] duty,
                                                   input logic [BEFF_W-1:0] b);
        return duty >> (BEFF_W'(DUTY_W) - b);
    endfunction

    function automatic logic [DUTY_W-1:0] frac_left(input logic [DUTY_W-1:0] duty,
                                                    input logic [BEFF_W-1:0] b);
        return duty << b;
    endfunction

endpackage

// File: rtl/bklt_prescale.sv
module bklt_prescale #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pre_q;

    assign tick = (pre_q >= div);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/bklt_regs.sv
module bklt_regs
    import bklt_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              period_end,
    output period_t           period,
    output mode_t             mode,
    output logic [DUTY_W-1:0] duty_next,
    output logic [DIV_W-1:0]  div,
    output logic              pending,
    output logic              master_ign
);
    logic [DUTY_W-1:0] per_val_q;
    logic [BITS_W-1:0] per_bits_q;
    mode_t             mode_q;
    logic [DUTY_W-1:0] shadow_q, active_q;
    logic              lock_q, ign_q, dirty_q, pend_q;
    logic [DIV_W-1:0]  div_q;

    reg_sel_e          sel;
    logic              xfer, set_pend;
    logic [BEFF_W-1:0] beff;
    logic [DUTY_W-1:0] msk, masked;

    assign sel    = reg_sel_e'(wr_sel);
    assign beff   = eff_bits(per_bits_q);
    assign msk    = bit_mask(beff);
    assign masked = per_val_q & msk;

    assign period.bits = beff;
    assign period.len  = (masked == '0) ? msk : masked;
    assign mode        = mode_q;
    assign div         = div_q;
    assign pending     = pend_q;
    assign master_ign  = ign_q;

    assign xfer      = pend_q && !lock_q && period_end;
    assign duty_next = xfer ? shadow_q : active_q;

    always_comb begin
        set_pend = 1'b0;
        if (wr_en) begin
            if (sel == SEL_CTRL && !lock_q) begin
                set_pend = 1'b1;
            end else if (sel == SEL_LOCK && lock_q && !wr_data[0] && dirty_q) begin
                set_pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_val_q  <= '0;
            per_bits_q <= '0;
            mode_q     <= '0;
            shadow_q   <= '0;
            active_q   <= '0;
            lock_q     <= 1'b0;
            ign_q      <= 1'b0;
            dirty_q    <= 1'b0;
            pend_q     <= 1'b0;
            div_q      <= '0;
        end else begin
            if (xfer) begin
                active_q <= shadow_q;
            end
            pend_q <= (pend_q && !xfer) || set_pend;
            if (wr_en) begin
                case (sel)
                    SEL_PERIOD: begin
                        per_val_q  <= wr_data[DUTY_W-1:0];
                        per_bits_q <= wr_data[REG_W-1:DUTY_W];
                    end
                    SEL_CTRL: begin
                        shadow_q    <= wr_data[DUTY_W-1:0];
                        mode_q.frac <= wr_data[DUTY_W];
                        mode_q.en   <= wr_data[DUTY_W+1];
                        if (lock_q) begin
                            dirty_q <= 1'b1;
                        end
                    end
                    SEL_LOCK: begin
                        lock_q <= wr_data[0];
                        ign_q  <= wr_data[1];
                        if (lock_q && !wr_data[0]) begin
                            dirty_q <= 1'b0;
                        end
                    end
                    SEL_DIV: begin
                        div_q <= wr_data[DIV_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (rst)
        $past(lock_q) |-> $stable(active_q)); // R8
    AST_XFER_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_q) |-> $past(period_end)); // R10
    AST_PEND_CLEARS_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_q) |-> $past(period_end)); // R9
endmodule

// File: rtl/bklt_core.sv
module bklt_core
    import bklt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  period_t           period,
    input  mode_t             mode,
    input  logic [DUTY_W-1:0] duty_next,
    output logic              period_end,
    output logic              pwm
);
    logic [DUTY_W-1:0] cnt_q, acc_q;
    logic [DUTY_W:0]   hi_q;
    logic              pwm_q;
    logic [DUTY_W:0]   sum;
    logic              carry;

    assign period_end = tick && (cnt_q >= period.len - 1'b1);
    assign sum   = {1'b0, acc_q} + {1'b0, frac_left(duty_next, period.bits)};
    assign carry = mode.frac && sum[DUTY_W];
    assign pwm   = pwm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            acc_q <= '0;
            hi_q  <= '0;
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= mode.en && ({1'b0, cnt_q} < hi_q);
            if (period_end) begin
                cnt_q <= '0;
                acc_q <= mode.frac ? sum[DUTY_W-1:0] : '0;
                hi_q  <= {1'b0, int_part(duty_next, period.bits)} + {{DUTY_W{1'b0}}, carry};
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
        !$past(mode.en) |-> !pwm_q); // R6
    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
        ($past(hi_q) == '0) |-> !pwm_q); // R4
endmodule

// File: rtl/bklt_pwm.sv
module bklt_pwm
    import bklt_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic             pwm_o,
    output logic             pending_o,
    output logic             master_ign_o
);
    period_t           period;
    mode_t             mode;
    logic [DUTY_W-1:0] duty_next;
    logic [DIV_W-1:0]  div;
    logic              tick, period_end;

    bklt_regs #(.DIV_W(DIV_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .period_end (period_end),
        .period     (period),
        .mode       (mode),
        .duty_next  (duty_next),
        .div        (div),
        .pending    (pending_o),
        .master_ign (master_ign_o)
    );

    bklt_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .div  (div),
        .tick (tick)
    );

    bklt_core u_core (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .period     (period),
        .mode       (mode),
        .duty_next  (duty_next),
        .period_end (period_end),
        .pwm        (pwm_o)
    );
endmodule

// File: tb/bklt_pwm_tb.sv
module bklt_pwm_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [19:0] wr_data = '0;
    logic        pwm_o, pending_o, master_ign_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bklt_pwm dut_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .pwm_o        (pwm_o),
        .pending_o    (pending_o),
        .master_ign_o (master_ign_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = 2'(sel);
        wr_data = 20'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic count_high(input int clocks, output int highs);
        highs = 0;
        for (int i = 0; i < clocks; i++) begin
            @(negedge clk);
            highs += int'(pwm_o);
        end
    endtask

    function automatic int beff(input int bits);
        return (bits == 0) ? 16 : bits;
    endfunction

    function automatic int plen(input int val, input int bits);
        int m;
        m = (1 << beff(bits)) - 1;
        return ((val & m) == 0) ? m : (val & m);
    endfunction

    function automatic int exp_high(input int val, input int bits, input int duty,
                                    input int frac, input int dv, input int nper);
        int p, d, f, h;
        p = plen(val, bits);
        d = duty >> (16 - beff(bits));
        f = duty & ((1 << (16 - beff(bits))) - 1);
        if (d >= p) h = nper * p;
        else        h = nper * d + (frac != 0 ? f : 0);
        return h * (dv + 1);
    endfunction

    task automatic measure(input string req, input int val, input int bits, input int duty,
                           input int frac, input int dv, input int nper);
        int highs;
        repeat (400) @(negedge clk);
        count_high(nper * plen(val, bits) * (dv + 1), highs);
        chk(req, highs, exp_high(val, bits, duty, frac, dv, nper));
    endtask

    task automatic wait_pend_clear(input string req, input int bound);
        int waited = 0;
        while (pending_o && waited < bound) begin
            @(negedge clk);
            waited++;
        end
        chk(req, int'(pending_o), 0);
    endtask

    localparam int EN = 1 << 17;
    localparam int FR = 1 << 16;

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int highs;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pwm after reset", int'(pwm_o), 0);
        chk("R1 pending after reset", int'(pending_o), 0);

        // R3: 12-bit count, period 20, D=5 with junk low bits ignored
        wr(0, (12 << 16) | 20);
        wr(3, 0);
        wr(1, EN | 16'h005F);
        measure("R3 integer duty", 20, 12, 16'h005F, 0, 0, 4);

        // R4: zero and over-full duty
        wr(1, EN | 16'h0000);
        measure("R4 zero duty low", 20, 12, 0, 0, 0, 4);
        wr(1, EN | (25 << 4));
        measure("R4 full duty high", 20, 12, 25 << 4, 0, 0, 4);

        // R6: disable lands on the second edge after the write
        chk("R6 high before disable", int'(pwm_o), 1);
        wr(1, 25 << 4);
        @(negedge clk);
        chk("R6 low after disable", int'(pwm_o), 0);
        count_high(100, highs);
        chk("R6 stays low", highs, 0);

        // R5: fractional mode D=7 F=5
        wr(1, EN | FR | 16'h0075);
        measure("R5 fractional duty", 20, 12, 16'h0075, 1, 0, 16);

        // R2: masked period value and 16-bit mode
        wr(0, (5 << 16) | 16'hFF14);
        wr(1, EN | (9 << 11));
        measure("R2 masked period", 16'hFF14, 5, 9 << 11, 0, 0, 4);
        wr(0, 30);
        wr(1, EN | 12);
        measure("R2 bit-count zero means 16", 30, 0, 12, 0, 0, 4);

        // R7: divider 3
        wr(0, (12 << 16) | 10);
        wr(3, 3);
        wr(1, EN | (3 << 4));
        measure("R7 reference divider", 10, 12, 3 << 4, 0, 3, 4);
        wr(3, 0);
        wr(0, (12 << 16) | 20);
        wr(1, EN | (5 << 4));
        repeat (400) @(negedge clk);

        // R8 / R9: locked update
        wr(2, 1);
        wr(1, EN | (15 << 4));
        chk("R8 no pending while locked", int'(pending_o), 0);
        measure("R8 locked duty frozen", 20, 12, 5 << 4, 0, 0, 4);
        chk("R8 still no pending", int'(pending_o), 0);
        wr(2, 0);
        chk("R9 pending after unlock", int'(pending_o), 1);
        wait_pend_clear("R9 pending clears", 20 + 3);
        measure("R9 new duty applied", 20, 12, 15 << 4, 0, 0, 4);

        // R10: unlocked write still waits for a boundary
        wr(1, EN | (8 << 4));
        chk("R10 pending after unlocked write", int'(pending_o), 1);
        wait_pend_clear("R10 pending clears", 20 + 3);
        measure("R10 duty applied", 20, 12, 8 << 4, 0, 0, 4);

        // R11: lock-ignore bit stored, no effect
        wr(2, 2);
        chk("R11 bit stored", int'(master_ign_o), 1);
        measure("R11 waveform unchanged", 20, 12, 8 << 4, 0, 0, 4);
        wr(1, EN | (11 << 4));
        chk("R11 write not held", int'(pending_o), 1);
        measure("R11 duty applied", 20, 12, 11 << 4, 0, 0, 4);
        wr(2, 0);
        chk("R11 bit cleared", int'(master_ign_o), 0);

        // Random mix of R3/R5/R7
        for (int it = 0; it < 20; it++) begin
            int p, d, f, fr, dv, duty;
            p    = 4 + int'($urandom % 37);
            d    = int'($urandom % (p + 3));
            f    = int'($urandom % 16);
            fr   = int'($urandom % 2);
            dv   = int'($urandom % 3);
            duty = (d << 4) | f;
            wr(0, (12 << 16) | p);
            wr(3, dv);
            wr(1, EN | (fr != 0 ? FR : 0) | duty);
            measure(fr != 0 ? "R5 random fractional" : "R3 random integer",
                    p, 12, duty, fr, dv, fr != 0 ? 16 : 4);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule